// File: doc/BRIEF.md
# Ethernet Receive Frame Ring

This block sits on the receive side of a small memory-mapped Ethernet MAC. Received frames enter as a byte stream, with a start marker on the first byte and an end marker on the last. Each accepted frame is written into one slot of a ring of `NSLOTS` slots of `SLOT_BYTES` bytes. In the slot, a 16-bit little-endian length comes first, then the frame bytes, then a CRC-32 computed while the bytes arrive. Software drains the ring one 32-bit word at a time through a data register. A count register tells it how many complete frames are waiting.

The block also holds a seven-bit raw event status register, an interrupt mask and a single interrupt line. All registers are reached over a simple word-addressed bus. Every read returns its data one cycle after the request. Frames must be separated by at least eight idle cycles, which is less than the standard Ethernet interframe gap. The block uses those cycles to append the CRC, the padding and the length field.

Top module: `eth_rx_ring`

## Requirements
- R1: A frame whose start marker arrives while the enable bit (bit 0 of the control register, address 2) is clear is discarded, and no count or status changes.
- R2: While `NSLOTS` frames are pending, a new frame is refused and never becomes visible. The pending count never exceeds `NSLOTS`.
- R3: A frame is stored in slot (head + pending) modulo `NSLOTS`. Frames are read out in arrival order, including across the wrap of the ring.
- R4: The stored image of an N-byte frame has this layout:
  - the 16-bit value N+6, low byte first;
  - the N frame bytes;
  - the CRC-32 (reflected polynomial 0xEDB88320, start value all ones, final inversion), low byte first;
  - zero bytes up to the next word boundary.
  A data read (address 3) returns image bytes 4k..4k+3, with byte 4k+j on bits 8j+7:8j.
- R5: A frame with N >= `SLOT_BYTES`-6 bytes is not stored. It sets status bit 3 (overrun) instead.
- R6: Each data read advances the read offset by 4. The read that reaches the stored length N+6 retires the frame: the offset returns to 0, the head advances modulo `NSLOTS`, and the count (address 4) drops by one.
- R7: A data read while no frame is pending returns 0 and changes no state.
- R8: A control write with bit 4 set clears the pending count and the read offset, and abandons any frame being received. Later frames then start at the same head slot.
- R9: Status bit 0 is set when a frame is stored. The interrupt output is high exactly when (status AND mask) is nonzero, with the mask at address 1. A write to address 0 clears the status bits written as 1, and a new event in the same cycle wins over the clear.
- R10: After reset the status is 0, the mask is 0x7F, the enable bit is 0 and the count is 0.
- R11: Every bus read is answered with `bus_rvalid` high on the cycle after the request, and `bus_rvalid` is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | 8 | Receive byte |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Word address (0 status/ack, 1 mask, 2 control, 3 data, 4 count) |
| bus_wdata | input | 7 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with `NSLOTS`=3 and `SLOT_BYTES`=32. With these values three frames fill the ring, so refusal of a fourth frame and the wrap of the slot index occur within a few frames. A 25-byte frame exactly fills a slot, and a 26-byte frame is the first oversize case. Frame lengths from 1 to 25 bytes cover every padding case at the end of a frame.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

  localparam int STAT_W = 7;

  // status bit positions
  localparam int ST_RX      = 0;
  localparam int ST_TXERR   = 1;
  localparam int ST_TXEMPTY = 2;
  localparam int ST_FOV     = 3;
  localparam int ST_RXERR   = 4;
  localparam int ST_MDIO    = 5;
  localparam int ST_PHY     = 6;

  localparam int CTRL_EN_BIT    = 0;
  localparam int CTRL_FLUSH_BIT = 4;

  typedef enum logic [2:0] {
    REG_STAT  = 3'd0,
    REG_MASK  = 3'd1,
    REG_CTRL  = 3'd2,
    REG_DATA  = 3'd3,
    REG_COUNT = 3'd4
  } reg_sel_e;

  typedef enum logic [2:0] {
    W_IDLE,
    W_DATA,
    W_DROP,
    W_CRC,
    W_PAD,
    W_LEN
  } wr_state_e;

  localparam logic [31:0] CRC_POLY = 32'hEDB88320;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'd0, b};
    for (int i = 0; i < 8; i++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/rxr_byte_ram.sv
module rxr_byte_ram #(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/rxr_frame_writer.sv
module rxr_frame_writer
  import rxr_pkg::*;
#(
  parameter int NSLOTS     = 31,
  parameter int SLOT_BYTES = 256,
  localparam int SW = $clog2(NSLOTS),
  localparam int PW = $clog2(SLOT_BYTES),
  localparam int CW = PW + 1,
  localparam int AW = SW + PW - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic              rx_en,
  input  logic              flush,
  input  logic [SW:0]       pending,
  input  logic [SW-1:0]     head,
  output logic [3:0]        lane_we,
  output logic [AW-1:0]     wr_addr,
  output logic [3:0][7:0]   lane_wdata,
  output logic              commit,
  output logic [SW-1:0]     commit_slot,
  output logic [CW-1:0]     commit_len,
  output logic              overrun
);

  localparam logic [SW:0]   NS_C     = (SW+1)'(NSLOTS);
  localparam logic [CW-1:0] LAST_IDX = CW'(SLOT_BYTES - 7);
  localparam logic [PW-1:0] FIRST_POS = PW'(2);

  wr_state_e      st;
  logic [SW-1:0]  slot;
  logic [CW-1:0]  nbytes;
  logic [PW-1:0]  pos;
  logic [31:0]    crc;
  logic [1:0]     cidx;

  logic [SW:0]    slot_sum;
  logic [SW-1:0]  tgt_slot;
  logic           start_ok;
  logic           at_limit;
  logic [31:0]    crc_fin;
  logic [15:0]    len16;

  always_comb begin
    slot_sum = {1'b0, head} + pending;
    tgt_slot = (slot_sum >= NS_C) ? SW'(slot_sum - NS_C) : SW'(slot_sum);
  end

  assign start_ok = rx_en && (pending != NS_C);
  assign at_limit = (nbytes == LAST_IDX);
  assign crc_fin  = ~crc;
  assign len16    = 16'(nbytes) + 16'd6;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= W_IDLE;
      slot   <= '0;
      nbytes <= '0;
      pos    <= '0;
      crc    <= '1;
      cidx   <= '0;
    end else if (flush) begin
      st <= W_IDLE;
    end else begin
      case (st)
        W_IDLE: begin
          if (in_valid && in_sof) begin
            if (start_ok) begin
              slot   <= tgt_slot;
              nbytes <= CW'(1);
              pos    <= FIRST_POS + PW'(1);
              crc    <= crc_step('1, in_data);
              cidx   <= '0;
              st     <= in_eof ? W_CRC : W_DATA;
            end else if (!in_eof) begin
              st <= W_DROP;
            end
          end
        end
        W_DATA: begin
          if (in_valid) begin
            if (at_limit) begin
              st <= in_eof ? W_IDLE : W_DROP;
            end else begin
              nbytes <= nbytes + CW'(1);
              pos    <= pos + PW'(1);
              crc    <= crc_step(crc, in_data);
              if (in_eof) begin
                st   <= W_CRC;
                cidx <= '0;
              end
            end
          end
        end
        W_DROP: begin
          if (in_valid && in_eof) st <= W_IDLE;
        end
        W_CRC: begin
          pos  <= pos + PW'(1);
          cidx <= cidx + 2'd1;
          if (cidx == 2'd3) st <= (pos[1:0] == 2'd3) ? W_LEN : W_PAD;
        end
        W_PAD: begin
          pos <= pos + PW'(1);
          if (pos[1:0] == 2'd3) st <= W_LEN;
        end
        W_LEN: st <= W_IDLE;
        default: st <= W_IDLE;
      endcase
    end
  end

  // write port: one byte per cycle, two bytes for the length field
  logic           wen;
  logic [PW-1:0]  wpos;
  logic [7:0]     wbyte;
  logic [SW-1:0]  wslot;

  always_comb begin
    wen   = 1'b0;
    wpos  = pos;
    wbyte = in_data;
    wslot = slot;
    case (st)
      W_IDLE: begin
        wen   = in_valid && in_sof && start_ok;
        wpos  = FIRST_POS;
        wslot = tgt_slot;
      end
      W_DATA: wen = in_valid && !at_limit;
      W_CRC: begin
        wen   = 1'b1;
        wbyte = crc_fin[8*cidx +: 8];
      end
      W_PAD: begin
        wen   = 1'b1;
        wbyte = 8'd0;
      end
      default: wen = 1'b0;
    endcase
  end

  always_comb begin
    lane_wdata = {4{wbyte}};
    if (st == W_LEN) begin
      lane_we       = flush ? 4'b0000 : 4'b0011;
      wr_addr       = {slot, {(PW-2){1'b0}}};
      lane_wdata[0] = len16[7:0];
      lane_wdata[1] = len16[15:8];
    end else begin
      lane_we = (wen && !flush) ? (4'b0001 << wpos[1:0]) : 4'b0000;
      wr_addr = {wslot, wpos[PW-1:2]};
    end
  end

  assign commit      = !flush && (st == W_LEN);
  assign commit_slot = slot;
  assign commit_len  = len16[CW-1:0];
  assign overrun     = !flush && (st == W_DATA) && in_valid && at_limit;

endmodule

// File: rtl/rxr_ring_ctrl.sv
module rxr_ring_ctrl #(
  parameter int NSLOTS     = 31,
  parameter int SLOT_BYTES = 256,
  localparam int SW = $clog2(NSLOTS),
  localparam int PW = $clog2(SLOT_BYTES),
  localparam int CW = PW + 1,
  localparam int AW = SW + PW - 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          commit,
  input  logic [SW-1:0] commit_slot,
  input  logic [CW-1:0] commit_len,
  input  logic          pop_req,
  output logic [SW-1:0] head,
  output logic [SW:0]   pending,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          pop_hit
);

  localparam logic [SW-1:0] LAST_SLOT = SW'(NSLOTS - 1);

  logic [CW-1:0] lens [NSLOTS];
  logic [CW-1:0] off;
  logic [CW-1:0] off_next;
  logic          retire;

  assign rd_en    = pop_req && (pending != '0);
  assign rd_addr  = {head, off[PW-1:2]};
  assign off_next = off + CW'(4);
  assign retire   = rd_en && (off_next >= lens[head]);

  always_ff @(posedge clk) begin
    if (commit) lens[commit_slot] <= commit_len;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head    <= '0;
      pending <= '0;
      off     <= '0;
      pop_hit <= 1'b0;
    end else begin
      pop_hit <= rd_en;
      if (flush) begin
        pending <= '0;
        off     <= '0;
      end else begin
        pending <= pending + (SW+1)'(commit) - (SW+1)'(retire);
        if (rd_en) begin
          if (retire) begin
            off  <= '0;
            head <= (head == LAST_SLOT) ? '0 : head + SW'(1);
          end else begin
            off <= off_next;
          end
        end
      end
    end
  end

endmodule

// File: rtl/eth_rx_ring.sv
module eth_rx_ring
  import rxr_pkg::*;
#(
  parameter int NSLOTS     = 31,
  parameter int SLOT_BYTES = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_sof,
  input  logic              rx_eof,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [2:0]        bus_addr,
  input  logic [STAT_W-1:0] bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  output logic              irq
);

  localparam int SW        = $clog2(NSLOTS);
  localparam int PW        = $clog2(SLOT_BYTES);
  localparam int CW        = PW + 1;
  localparam int AW        = SW + PW - 2;
  localparam int RAM_DEPTH = 1 << AW;

  logic [STAT_W-1:0] status_q;
  logic [STAT_W-1:0] mask_q;
  logic              rx_en_q;
  logic [2:0]        rd_sel_q;
  logic [31:0]       reg_q;

  logic [3:0]        lane_we;
  logic [AW-1:0]     wr_addr;
  logic [3:0][7:0]   lane_wdata;
  logic              commit;
  logic [SW-1:0]     commit_slot;
  logic [CW-1:0]     commit_len;
  logic              overrun;
  logic [SW-1:0]     head;
  logic [SW:0]       pending;
  logic              rd_en;
  logic [AW-1:0]     rd_addr;
  logic              pop_hit;
  logic [3:0][7:0]   lane_q;

  logic              flush;
  logic              pop_req;
  logic [STAT_W-1:0] ack_bits;
  logic [STAT_W-1:0] set_bits;

  assign flush    = bus_wr && (bus_addr == REG_CTRL) && bus_wdata[CTRL_FLUSH_BIT];
  assign pop_req  = bus_rd && (bus_addr == REG_DATA);
  assign ack_bits = (bus_wr && (bus_addr == REG_STAT)) ? bus_wdata : '0;

  always_comb begin
    set_bits         = '0;
    set_bits[ST_RX]  = commit;
    set_bits[ST_FOV] = overrun;
  end

  rxr_frame_writer #(.NSLOTS(NSLOTS), .SLOT_BYTES(SLOT_BYTES)) u_writer (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (rx_valid),
    .in_data     (rx_data),
    .in_sof      (rx_sof),
    .in_eof      (rx_eof),
    .rx_en       (rx_en_q),
    .flush       (flush),
    .pending     (pending),
    .head        (head),
    .lane_we     (lane_we),
    .wr_addr     (wr_addr),
    .lane_wdata  (lane_wdata),
    .commit      (commit),
    .commit_slot (commit_slot),
    .commit_len  (commit_len),
    .overrun     (overrun)
  );

  rxr_ring_ctrl #(.NSLOTS(NSLOTS), .SLOT_BYTES(SLOT_BYTES)) u_ring (
    .clk         (clk),
    .rst         (rst),
    .flush       (flush),
    .commit      (commit),
    .commit_slot (commit_slot),
    .commit_len  (commit_len),
    .pop_req     (pop_req),
    .head        (head),
    .pending     (pending),
    .rd_en       (rd_en),
    .rd_addr     (rd_addr),
    .pop_hit     (pop_hit)
  );

  for (genvar l = 0; l < 4; l++) begin : g_lane
    rxr_byte_ram #(.DEPTH(RAM_DEPTH)) u_ram (
      .clk   (clk),
      .we    (lane_we[l]),
      .waddr (wr_addr),
      .wdata (lane_wdata[l]),
      .re    (rd_en),
      .raddr (rd_addr),
      .rdata (lane_q[l])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q   <= '0;
      mask_q     <= '1;
      rx_en_q    <= 1'b0;
      rd_sel_q   <= REG_STAT;
      reg_q      <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      status_q   <= (status_q & ~ack_bits) | set_bits;
      bus_rvalid <= bus_rd;
      if (bus_wr && (bus_addr == REG_MASK)) mask_q  <= bus_wdata;
      if (bus_wr && (bus_addr == REG_CTRL)) rx_en_q <= bus_wdata[CTRL_EN_BIT];
      if (bus_rd) begin
        rd_sel_q <= bus_addr;
        case (bus_addr)
          REG_STAT:  reg_q <= 32'(status_q);
          REG_MASK:  reg_q <= 32'(mask_q);
          REG_CTRL:  reg_q <= 32'(rx_en_q);
          REG_COUNT: reg_q <= 32'(pending);
          default:   reg_q <= '0;
        endcase
      end
    end
  end

  assign bus_rdata = (rd_sel_q == REG_DATA) ? (pop_hit ? lane_q : 32'd0) : reg_q;
  assign irq       = |(status_q & mask_q);

endmodule

// File: rtl/rxr_checks.sv
module rxr_checks
  import rxr_pkg::*;
#(
  parameter int NSLOTS = 31,
  localparam int SW = $clog2(NSLOTS)
) (
  input logic              clk,
  input logic              rst,
  input logic              irq,
  input logic [STAT_W-1:0] status_q,
  input logic [STAT_W-1:0] mask_q,
  input logic [SW:0]       pending,
  input logic [SW-1:0]     head,
  input logic              commit,
  input logic              overrun,
  input logic              flush,
  input logic              bus_rd,
  input logic [2:0]        bus_addr,
  input logic              bus_rvalid
);

  localparam logic [SW:0] NS_C = (SW+1)'(NSLOTS);

  AST_PEND_LIMIT: assert property (@(posedge clk) disable iff (rst)
    pending <= NS_C); // R2
  AST_NO_COMMIT_FULL: assert property (@(posedge clk) disable iff (rst)
    commit |-> pending < NS_C); // R2
  AST_COMMIT_FLAGS_RX: assert property (@(posedge clk) disable iff (rst)
    commit |=> status_q[ST_RX]); // R9
  AST_OVERRUN_FLAGS_FOV: assert property (@(posedge clk) disable iff (rst)
    overrun |=> status_q[ST_FOV]); // R5
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    flush |=> pending == '0); // R8
  AST_EMPTY_READ_INERT: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == REG_DATA && pending == '0 && !commit && !flush)
      |=> (pending == '0 && $stable(head))); // R7
  AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid); // R11
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (mask_q == '0) |-> !irq); // R9

endmodule

bind eth_rx_ring rxr_checks #(.NSLOTS(NSLOTS)) u_checks (
  .clk        (clk),
  .rst        (rst),
  .irq        (irq),
  .status_q   (status_q),
  .mask_q     (mask_q),
  .pending    (pending),
  .head       (head),
  .commit     (commit),
  .overrun    (overrun),
  .flush      (flush),
  .bus_rd     (bus_rd),
  .bus_addr   (bus_addr),
  .bus_rvalid (bus_rvalid)
);

// File: tb/tb_eth_rx_ring.sv
module tb_eth_rx_ring;

  localparam int NS = 3;
  localparam int SB = 32;

  logic        clk = 1'b0;
  logic        rst;
  logic        rx_valid, rx_sof, rx_eof;
  logic [7:0]  rx_data;
  logic        bus_wr, bus_rd;
  logic [2:0]  bus_addr;
  logic [6:0]  bus_wdata;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        irq;

  always #5 clk = ~clk;

  eth_rx_ring #(.NSLOTS(NS), .SLOT_BYTES(SB)) dut (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_sof(rx_sof), .rx_eof(rx_eof), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .irq(irq)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] mon_exp;
  string       mon_tag;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // scoreboard monitor: every answered read is compared with the oldest expectation
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        check("R11 unexpected read data", 32'd1, 32'd0);
      end else begin
        mon_exp = exp_q.pop_front();
        mon_tag = tag_q.pop_front();
        check(mon_tag, bus_rdata, mon_exp);
      end
    end
  end

  function automatic logic [7:0] fb(int seed, int k);
    return 8'(seed * 37 + k * 13 + 5);
  endfunction

  function automatic logic [31:0] crc_of(int n, int seed);
    logic [31:0] c;
    logic [7:0]  b;
    c = 32'hFFFF_FFFF;
    for (int k = 0; k < n; k++) begin
      b = fb(seed, k);
      for (int i = 0; i < 8; i++) begin
        if ((c[0] ^ b[0]) == 1'b1) c = (c >> 1) ^ 32'hEDB88320;
        else c = c >> 1;
        b = b >> 1;
      end
    end
    return ~c;
  endfunction

  function automatic logic [31:0] frame_word(int n, int seed, int w);
    logic [31:0] crc;
    logic [31:0] r;
    int tot;
    crc = crc_of(n, seed);
    tot = n + 6;
    r = '0;
    for (int b = 0; b < 4; b++) begin
      int idx;
      logic [7:0] v;
      idx = 4 * w + b;
      if (idx == 0)          v = 8'(tot);
      else if (idx == 1)     v = 8'(tot >> 8);
      else if (idx < 2 + n)  v = fb(seed, idx - 2);
      else if (idx < 6 + n)  v = 8'(crc >> (8 * (idx - 2 - n)));
      else                   v = 8'd0;
      r[8*b +: 8] = v;
    end
    return r;
  endfunction

  // driver tasks: called right after a falling edge, return after the next one
  task automatic rd(logic [2:0] a, logic [31:0] exp, string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus_rd = 1'b1;
    bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wr(logic [2:0] a, logic [6:0] d);
    bus_wr = 1'b1;
    bus_addr = a;
    bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic drive_byte(logic [7:0] d, logic s, logic e);
    rx_valid = 1'b1;
    rx_data = d;
    rx_sof = s;
    rx_eof = e;
    @(negedge clk);
    rx_valid = 1'b0;
    rx_sof = 1'b0;
    rx_eof = 1'b0;
  endtask

  task automatic send_frame(int n, int seed);
    for (int k = 0; k < n; k++) drive_byte(fb(seed, k), k == 0, k == n - 1);
    repeat (12) @(negedge clk);
  endtask

  task automatic read_frame(int n, int seed, string tag);
    for (int w = 0; w < (n + 9) / 4; w++) rd(3'd3, frame_word(n, seed, w), tag);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    rst = 1'b1;
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_data = '0;
    bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R10 reset state
    check("R10 irq after reset", 32'(irq), 32'd0);
    check("R11 rvalid idle", 32'(bus_rvalid), 32'd0);
    rd(3'd0, 32'h00, "R10 status after reset");
    rd(3'd1, 32'h7F, "R10 mask after reset");
    rd(3'd2, 32'h00, "R10 control after reset");
    rd(3'd4, 32'd0,  "R10 count after reset");

    // R7 empty read
    rd(3'd3, 32'd0, "R7 empty data read returns zero");
    rd(3'd4, 32'd0, "R7 empty read leaves count");

    // R1 disabled receiver
    send_frame(5, 1);
    rd(3'd4, 32'd0, "R1 frame dropped while disabled");
    rd(3'd0, 32'd0, "R1 no status while disabled");

    // R4 R6 R9 basic frame
    wr(3'd2, 7'h01);
    rd(3'd2, 32'h01, "R1 enable readback");
    send_frame(5, 1);
    rd(3'd4, 32'd1, "R6 count after one frame");
    rd(3'd0, 32'h01, "R9 rx flag set");
    check("R9 irq with rx flag", 32'(irq), 32'd1);
    read_frame(5, 1, "R4 layout five byte frame");
    rd(3'd4, 32'd0, "R6 count after retire");
    rd(3'd3, 32'd0, "R7 read after drain");
    wr(3'd0, 7'h01);
    rd(3'd0, 32'h00, "R9 ack clears rx flag");
    check("R9 irq after ack", 32'(irq), 32'd0);

    // R2 R3 fill, refuse, wrap
    send_frame(1, 2);
    send_frame(2, 3);
    send_frame(3, 4);
    rd(3'd4, 32'd3, "R2 ring full count");
    send_frame(4, 5);
    rd(3'd4, 32'd3, "R2 frame refused when full");
    read_frame(1, 2, "R3 order first");
    read_frame(2, 3, "R3 order second");
    read_frame(3, 4, "R3 order third after wrap");
    rd(3'd4, 32'd0, "R6 count drained");
    rd(3'd3, 32'd0, "R2 refused frame absent");

    // R5 size limit
    send_frame(25, 6);
    rd(3'd4, 32'd1, "R5 largest frame accepted");
    read_frame(25, 6, "R4 largest frame layout");
    wr(3'd0, 7'h7F);
    send_frame(26, 7);
    rd(3'd4, 32'd0, "R5 oversize frame not stored");
    rd(3'd0, 32'h08, "R5 overrun flag");

    // R9 selective ack and mask
    send_frame(2, 8);
    rd(3'd0, 32'h09, "R9 rx and overrun pending");
    wr(3'd0, 7'h01);
    rd(3'd0, 32'h08, "R9 ack clears only written bits");
    wr(3'd1, 7'h00);
    check("R9 irq masked", 32'(irq), 32'd0);
    wr(3'd1, 7'h08);
    check("R9 irq unmasked source", 32'(irq), 32'd1);

    // R6 R8 partial read then flush
    rd(3'd3, frame_word(2, 8, 0), "R6 partial read first word");
    send_frame(3, 9);
    rd(3'd4, 32'd2, "R6 count before flush");
    wr(3'd2, 7'h11);
    rd(3'd4, 32'd0, "R8 flush clears count");
    rd(3'd3, 32'd0, "R8 flush leaves nothing to read");
    send_frame(4, 10);
    read_frame(4, 10, "R8 offset restarts after flush");
    rd(3'd4, 32'd0, "R8 count after post-flush frame");

    // R8 flush abandons a frame in flight
    for (int k = 0; k < 3; k++) drive_byte(fb(11, k), k == 0, 1'b0);
    wr(3'd2, 7'h11);
    for (int k = 3; k < 10; k++) drive_byte(fb(11, k), 1'b0, k == 9);
    repeat (12) @(negedge clk);
    rd(3'd4, 32'd0, "R8 abandoned frame not stored");
    send_frame(6, 12);
    read_frame(6, 12, "R3 ring intact after abandon");
    rd(3'd4, 32'd0, "R6 count final");

    repeat (4) @(negedge clk);
    check("R11 every read answered", 32'(exp_q.size()), 32'd0);
    summary();
  end

endmodule